// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block carries single-word messages between two independently clocked ports without going through the queue storage that normally sits between them. There are two mailboxes. One carries words from port A to port B, and the other carries words from port B to port A. The writing side owns a free flag for its mailbox. The flag drops when a word is accepted and rises again once the far side has consumed it. While the flag is low, further writes to that mailbox are ignored, so a pending message can never be overwritten.

On each port, a mailbox-select input decides whether an access goes to the mailbox or to the queue path. The block only decodes the queue path into write and read strobes; the queue itself lives elsewhere. The same select also steers the read data: with select high the port shows the incoming mailbox word, and with select low it shows the word presented on its queue-output input. An output-enable per port drives an external tristate pad.

Crossing events travel on toggle synchronizers. A write toggles a line into the reader's domain, and a consume toggles a line back into the writer's domain. Each mailbox has a writer FSM with the states WR_FREE and WR_HELD and the transitions *capture* (WR_FREE to WR_HELD, on a qualified write) and *release* (WR_HELD to WR_FREE, on the returned consume pulse). Each mailbox also has a reader FSM with the states RD_IDLE and RD_PENDING and the transitions *arrive* (RD_IDLE to RD_PENDING, on the synchronized write pulse) and *consume* (RD_PENDING to RD_IDLE, on a qualified mailbox read).

Top module: `mbox_pair_top`

## Requirements
- R1: An access happens only at a rising edge of the port's clock with that port's `*_cs_n` low and `*_en` high; otherwise the edge changes neither flag nor mailbox.
- R2: A qualified write with `*_wr`=1 and `*_mbsel`=1 while the port's own mailbox flag is high stores `*_din` and makes the flag read 0 right after that same edge.
- R3: A mailbox write while that mailbox's flag is low is discarded; the stored word stays unchanged.
- R4: A qualified read with `*_wr`=0 and `*_mbsel`=1 on the receiving port, once the message has arrived there, sets the writer's flag back to 1 no later than the fourth writer-clock rising edge after the read edge.
- R5: A mailbox read on the receiving port while no message is pending there returns the current (stale) stored word and leaves the writer's flag unchanged.
- R6: `*_dout` shows the opposite-direction mailbox word when `*_mbsel`=1 and the port's `*_fifo_q` input when `*_mbsel`=0.
- R7: `*_oe` is 1 exactly when `*_cs_n`=0 and `*_wr`=0; it is 0 whenever chip select is high or the port is in write mode.
- R8: `rst_ab_n` low forces the A-to-B mailbox flag (`a_mb_free`) to 1 and clears that mailbox to zero; `rst_ba_n` does the same for `b_mb_free`; neither reset touches the other mailbox.
- R9: The B-to-A mailbox obeys R2 through R5 with the ports swapped: B writes, A reads, and `b_mb_free` is in the clk_b domain.
- R10: A qualified access with `*_mbsel`=0 leaves both mailboxes and flags untouched and instead raises `*_fifo_wr` (write) or `*_fifo_rd` (read) combinationally during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock, unrelated to clk_a |
| rst_ab_n | input | 1 | Async active-low reset of the A-to-B path |
| rst_ba_n | input | 1 | Async active-low reset of the B-to-A path |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_en | input | 1 | Port A access enable |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_mbsel | input | 1 | Port A mailbox select: 1 mailbox, 0 queue path |
| a_din | input | DATA_W | Port A write data |
| a_fifo_q | input | DATA_W | Queue output word shown on port A |
| a_dout | output | DATA_W | Port A read data |
| a_oe | output | 1 | Port A pad output enable |
| a_fifo_wr | output | 1 | Port A queue write strobe |
| a_fifo_rd | output | 1 | Port A queue read strobe |
| a_mb_free | output | 1 | A-to-B mailbox free flag (clk_a domain) |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_en | input | 1 | Port B access enable |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_mbsel | input | 1 | Port B mailbox select |
| b_din | input | DATA_W | Port B write data |
| b_fifo_q | input | DATA_W | Queue output word shown on port B |
| b_dout | output | DATA_W | Port B read data |
| b_oe | output | 1 | Port B pad output enable |
| b_fifo_wr | output | 1 | Port B queue write strobe |
| b_fifo_rd | output | 1 | Port B queue read strobe |
| b_mb_free | output | 1 | B-to-A mailbox free flag (clk_b domain) |

## Verification
The bench fires a second write into a mailbox that is already held and then reads back the first word. A design that let the write through would return the second word. It also issues a mailbox read at the receiver before any message has arrived. A design that treated that read as a consume would raise the writer's flag spuriously, or would later drop a real message. It resets one direction while both mailboxes are held, which catches a design that shares reset state between the two paths. It checks how many writer-clock edges the flag needs to return after a consume, which exposes a missing or extra synchronizer stage. Random mixed accesses on both ports, with chip select and enable off at times, are compared against a bench model of both flags and both stored words.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    typedef enum logic {
        WR_FREE = 1'b0,
        WR_HELD = 1'b1
    } wr_state_t;

    typedef enum logic {
        RD_IDLE    = 1'b0,
        RD_PENDING = 1'b1
    } rd_state_t;
endpackage

// File: rtl/tog_sync.sv
module tog_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic pulse
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain;
    logic         last;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= tog_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[TOP-1:0], tog_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last <= 1'b0;
        else        last <= chain[TOP];
    end

    assign pulse = chain[TOP] ^ last;
endmodule

// File: rtl/mbox_wr_fsm.sv
module mbox_wr_fsm
    import mbox_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack_pulse,
    output logic              free,
    output logic [DATA_W-1:0] mail,
    output logic              post_tog
);
    wr_state_t state, state_nx;
    logic      capture;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WR_FREE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        capture  = 1'b0;
        unique case (state)
            WR_FREE: begin
                if (wr_hit) begin
                    state_nx = WR_HELD;
                    capture  = 1'b1;
                end
            end
            WR_HELD: begin
                if (ack_pulse) state_nx = WR_FREE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mail     <= '0;
            post_tog <= 1'b0;
        end else if (capture) begin
            mail     <= wdata;
            post_tog <= ~post_tog;
        end
    end

    always_comb begin
        free = (state == WR_FREE);
    end

    AST_WR_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && free) |=> (!free && mail == $past(wdata))) else $error("capture"); // R2
    AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !free) |=> $stable(mail)) else $error("blocked"); // R3
    AST_FLAG_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(free) |-> $past(ack_pulse)) else $error("release"); // R4
endmodule

// File: rtl/mbox_rd_fsm.sv
module mbox_rd_fsm
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arrive_pulse,
    input  logic rd_hit,
    output logic pending,
    output logic ack_tog
);
    rd_state_t state, state_nx;
    logic      consume;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RD_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        consume  = 1'b0;
        unique case (state)
            RD_IDLE: begin
                if (arrive_pulse) state_nx = RD_PENDING;
            end
            RD_PENDING: begin
                if (rd_hit) begin
                    state_nx = RD_IDLE;
                    consume  = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ack_tog <= 1'b0;
        else if (consume) ack_tog <= ~ack_tog;
    end

    always_comb begin
        pending = (state == RD_PENDING);
    end

    AST_STALE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !pending) |=> $stable(ack_tog)) else $error("stale read acked"); // R5
    AST_ACK_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_tog != $past(ack_tog)) |-> $past(rd_hit && pending)) else $error("ack w/o read"); // R4
endmodule

// File: rtl/mbox_chan.sv
module mbox_chan #(
    parameter int DATA_W      = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_w,
    input  logic              clk_r,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_hit,
    output logic              free,
    output logic [DATA_W-1:0] mail
);
    logic post_tog, ack_tog, arrive_pulse, ack_pulse, pending;

    mbox_wr_fsm #(.DATA_W(DATA_W)) u_wr (
        .clk(clk_w), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(wdata),
        .ack_pulse(ack_pulse), .free(free), .mail(mail), .post_tog(post_tog)
    );

    tog_sync #(.STAGES(SYNC_STAGES)) u_fwd (
        .clk(clk_r), .rst_n(rst_n), .tog_in(post_tog), .pulse(arrive_pulse)
    );

    mbox_rd_fsm u_rd (
        .clk(clk_r), .rst_n(rst_n), .arrive_pulse(arrive_pulse), .rd_hit(rd_hit),
        .pending(pending), .ack_tog(ack_tog)
    );

    tog_sync #(.STAGES(SYNC_STAGES)) u_back (
        .clk(clk_w), .rst_n(rst_n), .tog_in(ack_tog), .pulse(ack_pulse)
    );

    AST_ARRIVE_WHILE_IDLE: assert property (@(posedge clk_r) disable iff (!rst_n)
        arrive_pulse |-> !pending) else $error("second arrival"); // R3
endmodule

// File: rtl/mbox_port.sv
module mbox_port #(
    parameter int DATA_W = 36
) (
    input  logic              cs_n,
    input  logic              en,
    input  logic              wr,
    input  logic              mbsel,
    input  logic [DATA_W-1:0] fifo_q,
    input  logic [DATA_W-1:0] mail_in,
    output logic              mb_wr_hit,
    output logic              mb_rd_hit,
    output logic              fifo_wr,
    output logic              fifo_rd,
    output logic [DATA_W-1:0] dout,
    output logic              oe
);
    logic access;

    always_comb begin
        access    = !cs_n && en;
        mb_wr_hit = access &&  wr &&  mbsel;
        mb_rd_hit = access && !wr &&  mbsel;
        fifo_wr   = access &&  wr && !mbsel;
        fifo_rd   = access && !wr && !mbsel;
        oe        = !cs_n && !wr;
        dout      = mbsel ? mail_in : fifo_q;
    end
endmodule

// File: rtl/mbox_pair_top.sv
module mbox_pair_top #(
    parameter int DATA_W      = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst_ab_n,
    input  logic              rst_ba_n,
    input  logic              a_cs_n,
    input  logic              a_en,
    input  logic              a_wr,
    input  logic              a_mbsel,
    input  logic [DATA_W-1:0] a_din,
    input  logic [DATA_W-1:0] a_fifo_q,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_oe,
    output logic              a_fifo_wr,
    output logic              a_fifo_rd,
    output logic              a_mb_free,
    input  logic              b_cs_n,
    input  logic              b_en,
    input  logic              b_wr,
    input  logic              b_mbsel,
    input  logic [DATA_W-1:0] b_din,
    input  logic [DATA_W-1:0] b_fifo_q,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_oe,
    output logic              b_fifo_wr,
    output logic              b_fifo_rd,
    output logic              b_mb_free
);
    logic              a_wr_hit, a_rd_hit, b_wr_hit, b_rd_hit;
    logic [DATA_W-1:0] mail_ab, mail_ba;

    mbox_port #(.DATA_W(DATA_W)) u_port_a (
        .cs_n(a_cs_n), .en(a_en), .wr(a_wr), .mbsel(a_mbsel), .fifo_q(a_fifo_q),
        .mail_in(mail_ba), .mb_wr_hit(a_wr_hit), .mb_rd_hit(a_rd_hit),
        .fifo_wr(a_fifo_wr), .fifo_rd(a_fifo_rd), .dout(a_dout), .oe(a_oe)
    );

    mbox_port #(.DATA_W(DATA_W)) u_port_b (
        .cs_n(b_cs_n), .en(b_en), .wr(b_wr), .mbsel(b_mbsel), .fifo_q(b_fifo_q),
        .mail_in(mail_ab), .mb_wr_hit(b_wr_hit), .mb_rd_hit(b_rd_hit),
        .fifo_wr(b_fifo_wr), .fifo_rd(b_fifo_rd), .dout(b_dout), .oe(b_oe)
    );

    mbox_chan #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ab (
        .clk_w(clk_a), .clk_r(clk_b), .rst_n(rst_ab_n),
        .wr_hit(a_wr_hit), .wdata(a_din), .rd_hit(b_rd_hit),
        .free(a_mb_free), .mail(mail_ab)
    );

    mbox_chan #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ba (
        .clk_w(clk_b), .clk_r(clk_a), .rst_n(rst_ba_n),
        .wr_hit(b_wr_hit), .wdata(b_din), .rd_hit(a_rd_hit),
        .free(b_mb_free), .mail(mail_ba)
    );

    AST_A_DESELECT_NO_CHANGE: assert property (@(posedge clk_a) disable iff (!rst_ab_n)
        (a_cs_n && a_mb_free) |=> a_mb_free) else $error("deselected write"); // R1
    AST_B_DESELECT_NO_CHANGE: assert property (@(posedge clk_b) disable iff (!rst_ba_n)
        (b_cs_n && b_mb_free) |=> b_mb_free) else $error("deselected write"); // R9
    AST_A_QUEUE_PATH: assert property (@(posedge clk_a) disable iff (!rst_ab_n)
        (a_fifo_wr && a_mb_free) |=> a_mb_free) else $error("queue write hit mailbox"); // R10
endmodule

// File: tb/sim_mbox_pair_top.sv
module sim_mbox_pair_top;
    localparam int DW = 36;

    logic clk_a = 1'b0, clk_b = 1'b0;
    logic rst_ab_n = 1'b0, rst_ba_n = 1'b0;
    logic a_cs_n = 1'b1, a_en = 1'b0, a_wr = 1'b0, a_mbsel = 1'b0;
    logic b_cs_n = 1'b1, b_en = 1'b0, b_wr = 1'b0, b_mbsel = 1'b0;
    logic [DW-1:0] a_din = '0, b_din = '0, a_fifo_q = 36'h0_1111_2222, b_fifo_q = 36'h0_3333_4444;
    logic [DW-1:0] a_dout, b_dout;
    logic a_oe, b_oe, a_fifo_wr, a_fifo_rd, b_fifo_wr, b_fifo_rd, a_mb_free, b_mb_free;

    int checks = 0, failures = 0;
    bit done = 0;

    // model
    bit            m_free_ab, m_free_ba;
    logic [DW-1:0] m_ab, m_ba;

    always #5 clk_a = ~clk_a;
    always #7 clk_b = ~clk_b;

    mbox_pair_top #(.DATA_W(DW)) u0 (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rnd_word();
        return DW'({$urandom(), $urandom()});
    endfunction

    task automatic op_a(input bit cs_n, input bit en, input bit wr, input bit sel, input logic [DW-1:0] d);
        @(negedge clk_a);
        a_cs_n = cs_n; a_en = en; a_wr = wr; a_mbsel = sel; a_din = d;
        @(posedge clk_a); #1;
        a_cs_n = 1'b1; a_en = 1'b0;
    endtask

    task automatic op_b(input bit cs_n, input bit en, input bit wr, input bit sel, input logic [DW-1:0] d);
        @(negedge clk_b);
        b_cs_n = cs_n; b_en = en; b_wr = wr; b_mbsel = sel; b_din = d;
        @(posedge clk_b); #1;
        b_cs_n = 1'b1; b_en = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(posedge clk_b);
        repeat (6) @(posedge clk_a);
        @(negedge clk_a);
    endtask

    task automatic peek_b(output logic [DW-1:0] v);
        b_cs_n = 1'b0; b_en = 1'b0; b_wr = 1'b0; b_mbsel = 1'b1; #1;
        v = b_dout; b_cs_n = 1'b1;
    endtask

    task automatic peek_a(output logic [DW-1:0] v);
        a_cs_n = 1'b0; a_en = 1'b0; a_wr = 1'b0; a_mbsel = 1'b1; #1;
        v = a_dout; a_cs_n = 1'b1;
    endtask

    function automatic void model_a(bit cs_n, bit en, bit wr, bit sel, logic [DW-1:0] d);
        if (!cs_n && en && sel) begin
            if (wr && m_free_ab) begin m_ab = d; m_free_ab = 0; end
            else if (!wr && !m_free_ba) m_free_ba = 1;
        end
    endfunction

    function automatic void model_b(bit cs_n, bit en, bit wr, bit sel, logic [DW-1:0] d);
        if (!cs_n && en && sel) begin
            if (wr && m_free_ba) begin m_ba = d; m_free_ba = 0; end
            else if (!wr && !m_free_ab) m_free_ab = 1;
        end
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        void'($urandom(32'h5eed));
        repeat (3) @(posedge clk_a);
        rst_ab_n = 1'b1; rst_ba_n = 1'b1;
        settle();

        // R8 reset state, R7 deselected pads
        check("R8 a_mb_free after reset", a_mb_free, 1);
        check("R8 b_mb_free after reset", b_mb_free, 1);
        check("R7 a_oe deselected", a_oe, 0);
        check("R7 b_oe deselected", b_oe, 0);

        // R10 queue path strobes, R7 write-mode oe
        @(negedge clk_a);
        a_cs_n = 0; a_en = 1; a_wr = 1; a_mbsel = 0; #1;
        check("R10 a_fifo_wr strobe", a_fifo_wr, 1);
        check("R7 a_oe low in write mode", a_oe, 0);
        @(posedge clk_a); #1; a_cs_n = 1; a_en = 0;
        check("R10 queue write leaves flag", a_mb_free, 1);
        @(negedge clk_b);
        b_cs_n = 0; b_en = 1; b_wr = 0; b_mbsel = 0; #1;
        check("R10 b_fifo_rd strobe", b_fifo_rd, 1);
        check("R6 b_dout shows fifo_q", b_dout, b_fifo_q);
        check("R7 b_oe in read mode", b_oe, 1);
        @(posedge clk_b); #1; b_cs_n = 1; b_en = 0;

        // R1 unqualified writes
        op_a(1, 1, 1, 1, 36'h0_dead_0001);
        check("R1 write with cs_n high ignored", a_mb_free, 1);
        op_a(0, 0, 1, 1, 36'h0_dead_0002);
        check("R1 write with en low ignored", a_mb_free, 1);

        // R2 capture
        op_a(0, 1, 1, 1, 36'h9_abcd_0123);
        check("R2 flag low after write edge", a_mb_free, 0);
        // R3 blocked write
        op_a(0, 1, 1, 1, 36'h5_5555_5555);
        settle();
        check("R3 flag still low", a_mb_free, 0);
        @(negedge clk_b); peek_b(v);
        check("R3 first word kept", v, 36'h9_abcd_0123);

        // R4 consume and release timing
        op_b(0, 1, 0, 1, '0);
        repeat (4) @(posedge clk_a); #1;
        check("R4 flag high within 4 writer edges", a_mb_free, 1);

        // R5 stale read
        op_b(0, 1, 0, 1, '0);
        settle();
        check("R5 stale read leaves flag", a_mb_free, 1);
        @(negedge clk_b); peek_b(v);
        check("R5 stale word returned", v, 36'h9_abcd_0123);

        // R9 reverse direction
        op_b(0, 1, 1, 1, 36'h7_0f0f_0f0f);
        check("R9 b flag low after write", b_mb_free, 0);
        op_b(0, 1, 1, 1, 36'h1_0000_0001);
        settle();
        @(negedge clk_a); peek_a(v);
        check("R9 blocked write keeps word", v, 36'h7_0f0f_0f0f);
        @(negedge clk_a);
        a_cs_n = 0; a_wr = 0; a_mbsel = 0; #1;
        check("R6 a_dout shows fifo_q", a_dout, a_fifo_q);
        a_cs_n = 1;
        op_a(0, 1, 0, 1, '0);
        repeat (4) @(posedge clk_b); #1;
        check("R9 b flag released", b_mb_free, 1);

        // R8 independent resets
        op_a(0, 1, 1, 1, 36'h2_2222_2222);
        op_b(0, 1, 1, 1, 36'h3_3333_3333);
        settle();
        @(negedge clk_a); rst_ab_n = 0; #1;
        check("R8 a flag forced high", a_mb_free, 1);
        check("R8 other path untouched", b_mb_free, 0);
        @(negedge clk_a); rst_ab_n = 1;
        settle();
        @(negedge clk_b); peek_b(v);
        check("R8 mailbox cleared", v, 0);
        @(negedge clk_a); peek_a(v);
        check("R8 other mailbox kept", v, 36'h3_3333_3333);

        // model sync
        m_free_ab = 1; m_ab = '0; m_free_ba = 0; m_ba = 36'h3_3333_3333;

        // random mix
        for (int i = 0; i < 80; i++) begin
            bit cs_n, en, wr, sel;
            logic [DW-1:0] d;
            cs_n = ($urandom() % 5) == 0;
            en   = ($urandom() % 5) != 0;
            wr   = $urandom() % 2;
            sel  = ($urandom() % 6) != 0;
            d    = rnd_word();
            if ($urandom() % 2) begin
                op_a(cs_n, en, wr, sel, d); model_a(cs_n, en, wr, sel, d);
            end else begin
                op_b(cs_n, en, wr, sel, d); model_b(cs_n, en, wr, sel, d);
            end
            settle();
            check("R2/R4 random a flag", a_mb_free, m_free_ab);
            check("R9 random b flag", b_mb_free, m_free_ba);
            @(negedge clk_b); peek_b(v);
            check("R3/R6 random ab word", v, m_ab);
            @(negedge clk_a); peek_a(v);
            check("R9 random ba word", v, m_ba);
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule